// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a 16-bit segment and a 16-bit offset into a 21-bit physical byte address. It uses the same scheme as a processor running in real mode. It holds four segment registers: code, data, extra and stack. A write port loads them. For each request, the access kind picks the default segment. An optional override can take its place, but only where the override is allowed.

The segment value is shifted left by four bits and the zero-extended offset is added to it. The sum is registered and appears one clock after the request, together with a valid strobe. A gate control sets the top address bit. When the gate is closed, addresses fold back into the first megabyte. When it is open, they can reach the area just above 1 MB, up to 10FFEFh.

A separate combinational stepper gives the next string index. It adds or subtracts the element size, and the direction flag picks which.

Top module: `rm_addr_gen`

## Requirements
- R1: With `a20_en_i` high, the registered address equals segment × 16 + offset as a 21-bit sum; segment FFFFh with offset FFFFh gives 10FFEFh.
- R2: With `a20_en_i` low, bit 20 of the address is 0, so FFFFh:0010h gives 000000h and FFFFh:FFFFh gives 0FFEFh.
- R3: Access codes select a default segment: 0 instruction fetch uses code, 1 stack uses stack, 2 data uses data, 3 string destination uses extra.
- R4: When `ovr_en_i` is high on a stack (1) or data (2) access, the segment named by `ovr_sel_i` is used instead (0 code, 1 data, 2 extra, 3 stack).
- R5: `ovr_en_i` has no effect on instruction fetch (0) or string destination (3) accesses.
- R6: `pa_vld_o` is high exactly in the cycle after a cycle with `req_i` high, and `pa_o` changes only in that cycle; otherwise it holds its last value.
- R7: A clock edge with `seg_we_i` high loads `seg_wdata_i` into the register that `seg_wsel_i` names (same encoding as R4). Without `seg_we_i`, no register changes. A request in the same cycle as a write uses the value held before the write.
- R8: After reset all segment registers are 0, `pa_o` is 0 and `pa_vld_o` is 0.
- R9: `str_idx_o` equals `str_idx_i` plus the step when `str_dir_i` is 0, and minus the step when it is 1. The step is 1 when `str_word_i` is 0 and 2 when it is 1. The result wraps modulo 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seg_we_i | input | 1 | Segment register write enable |
| seg_wsel_i | input | 2 | Segment register to write |
| seg_wdata_i | input | 16 | Segment write value |
| req_i | input | 1 | Address request |
| acc_i | input | 2 | Access kind |
| ovr_en_i | input | 1 | Segment override enable |
| ovr_sel_i | input | 2 | Override segment |
| ofs_i | input | 16 | Offset |
| a20_en_i | input | 1 | Let bit 20 through |
| pa_o | output | 21 | Physical address |
| pa_vld_o | output | 1 | Address valid strobe |
| str_idx_i | input | 16 | Current string index |
| str_dir_i | input | 1 | Direction: 0 up, 1 down |
| str_word_i | input | 1 | Element size: 0 byte, 1 word |
| str_idx_o | output | 16 | Next string index |

## Verification
The address and its strobe are due one clock after the request, so the bench drives each request on a falling edge and reads `pa_o` on the next falling edge. At that point exactly one rising edge has passed. A segment write takes effect on the same rising edge as a request made in that cycle, so the bench checks that such a request still sees the old value and that the next request sees the new one. The index stepper has no register, so its output is read on the same falling edge that its inputs are set.

// File: rtl/rm_addr_pkg.sv
package rm_addr_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_STACK = 2'd1,
    ACC_DATA  = 2'd2,
    ACC_SDST  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_EXTRA = 2'd2,
    SEG_STACK = 2'd3
  } seg_e;

  localparam int unsigned NSEG = 4;
endpackage

// File: rtl/rm_seg_regs.sv
module rm_seg_regs
  import rm_addr_pkg::*;
#(
  parameter int unsigned SEG_W = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [1:0]                 wsel_i,
  input  logic [SEG_W-1:0]           wdata_i,
  output logic [NSEG-1:0][SEG_W-1:0] seg_o
);
  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) seg_o[g] <= '0;
      else if (we_i && wsel_i == 2'(g)) seg_o[g] <= wdata_i;
    end
  end

  // R7: registers move only on a write
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(seg_o));
endmodule

// File: rtl/rm_seg_select.sv
module rm_seg_select
  import rm_addr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] acc_i,
  input  logic       ovr_en_i,
  input  logic [1:0] ovr_sel_i,
  output logic [1:0] sel_o
);
  seg_e dflt;

  always_comb begin
    unique case (acc_e'(acc_i))
      ACC_FETCH: dflt = SEG_CODE;
      ACC_STACK: dflt = SEG_STACK;
      ACC_DATA:  dflt = SEG_DATA;
      default:   dflt = SEG_EXTRA;
    endcase
  end

  // override only on stack and data accesses
  always_comb begin
    sel_o = dflt;
    if (ovr_en_i && (acc_i == ACC_STACK || acc_i == ACC_DATA)) sel_o = ovr_sel_i;
  end

  a_r5_fetch_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i == ACC_FETCH |-> sel_o == SEG_CODE);
  a_r5_sdst_extra: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i == ACC_SDST |-> sel_o == SEG_EXTRA);
endmodule

// File: rtl/rm_pa_adder.sv
module rm_pa_adder #(
  parameter int unsigned SEG_W = 16,
  parameter int unsigned OFS_W = 16,
  parameter int unsigned SHIFT = 4,
  localparam int unsigned PA_W = SEG_W + SHIFT + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [SEG_W-1:0] seg_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic             a20_en_i,
  output logic [PA_W-1:0]  pa_o,
  output logic             vld_o
);
  logic [PA_W-1:0] base, ext_ofs, sum, gated;

  assign base    = {1'b0, seg_i, {SHIFT{1'b0}}};
  assign ext_ofs = {{(PA_W-OFS_W){1'b0}}, ofs_i};
  assign sum     = base + ext_ofs;

  always_comb begin
    gated = sum;
    if (!a20_en_i) gated[PA_W-1] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pa_o  <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= req_i;
      if (req_i) pa_o <= gated;
    end
  end

  a_r6_vld_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> vld_o);
  a_r6_no_spurious_vld: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !vld_o && $stable(pa_o));
  a_r2_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !a20_en_i |=> !pa_o[PA_W-1]);
  a_r1_low_nibble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> pa_o[SHIFT-1:0] == $past(ofs_i[SHIFT-1:0]));
endmodule

// File: rtl/rm_idx_step.sv
module rm_idx_step #(
  parameter int unsigned IDX_W = 16
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic             dir_i,
  input  logic             word_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] ONE = IDX_W'(1);
  logic [IDX_W-1:0] step, diff;

  assign step  = word_i ? (ONE << 1) : ONE;
  assign idx_o = dir_i ? idx_i - step : idx_i + step;
  assign diff  = idx_o - idx_i;

  // R9: magnitude of the move is one or two elements
  always_comb begin
    if (!$isunknown({idx_i, dir_i, word_i}))
      a_r9_step_size: assert (diff == ONE || diff == (ONE << 1) ||
                              diff == '1 || diff == ('1 - ONE));
  end
endmodule

// File: rtl/rm_addr_gen.sv
module rm_addr_gen
  import rm_addr_pkg::*;
#(
  parameter int unsigned SEG_W = 16,
  parameter int unsigned OFS_W = 16,
  parameter int unsigned SHIFT = 4,
  localparam int unsigned PA_W = SEG_W + SHIFT + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             seg_we_i,
  input  logic [1:0]       seg_wsel_i,
  input  logic [SEG_W-1:0] seg_wdata_i,
  input  logic             req_i,
  input  logic [1:0]       acc_i,
  input  logic             ovr_en_i,
  input  logic [1:0]       ovr_sel_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic             a20_en_i,
  output logic [PA_W-1:0]  pa_o,
  output logic             pa_vld_o,
  input  logic [OFS_W-1:0] str_idx_i,
  input  logic             str_dir_i,
  input  logic             str_word_i,
  output logic [OFS_W-1:0] str_idx_o
);
  logic [NSEG-1:0][SEG_W-1:0] seg_q;
  logic [1:0]                 sel;

  rm_seg_regs #(.SEG_W(SEG_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(seg_we_i), .wsel_i(seg_wsel_i), .wdata_i(seg_wdata_i),
    .seg_o(seg_q)
  );

  rm_seg_select u_sel (
    .clk_i, .rst_ni,
    .acc_i, .ovr_en_i, .ovr_sel_i,
    .sel_o(sel)
  );

  rm_pa_adder #(.SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SHIFT)) u_add (
    .clk_i, .rst_ni,
    .req_i, .seg_i(seg_q[sel]), .ofs_i, .a20_en_i,
    .pa_o, .vld_o(pa_vld_o)
  );

  rm_idx_step #(.IDX_W(OFS_W)) u_step (
    .idx_i(str_idx_i), .dir_i(str_dir_i), .word_i(str_word_i),
    .idx_o(str_idx_o)
  );
endmodule

// File: tb/rm_addr_gen_tb.sv
module rm_addr_gen_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        seg_we = 0;
  logic [1:0]  seg_wsel = 0;
  logic [15:0] seg_wdata = 0;
  logic        req = 0;
  logic [1:0]  acc = 0;
  logic        oen = 0;
  logic [1:0]  osel = 0;
  logic [15:0] ofs = 0;
  logic        a20 = 1;
  logic [20:0] pa;
  logic        vld;
  logic [15:0] sidx = 0;
  logic        sdir = 0, sword = 0;
  logic [15:0] sidx_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10ns clk = ~clk;

  rm_addr_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .seg_we_i(seg_we), .seg_wsel_i(seg_wsel), .seg_wdata_i(seg_wdata),
    .req_i(req), .acc_i(acc), .ovr_en_i(oen), .ovr_sel_i(osel),
    .ofs_i(ofs), .a20_en_i(a20),
    .pa_o(pa), .pa_vld_o(vld),
    .str_idx_i(sidx), .str_dir_i(sdir), .str_word_i(sword), .str_idx_o(sidx_o)
  );

  typedef struct packed {
    logic [1:0]  acc;
    logic        oen;
    logic [1:0]  osel;
    logic [15:0] ofs;
    logic        a20;
    logic [20:0] pa;
  } vec_t;

  // segments: code 090F, data 0A0F, extra 2000, stack 0A28
  localparam vec_t VECS [8] = '{
    '{2'd0, 1'b0, 2'd0, 16'h0100, 1'b1, 21'h091F0},  // R3 fetch
    '{2'd2, 1'b0, 2'd0, 16'h0010, 1'b1, 21'h0A100},  // R3 data
    '{2'd1, 1'b0, 2'd0, 16'h01FE, 1'b1, 21'h0A47E},  // R3 stack
    '{2'd3, 1'b0, 2'd0, 16'h3456, 1'b1, 21'h23456},  // R3 string dest
    '{2'd2, 1'b1, 2'd2, 16'h0004, 1'b1, 21'h20004},  // R4 data->extra
    '{2'd1, 1'b1, 2'd1, 16'h0008, 1'b1, 21'h0A0F8},  // R4 stack->data
    '{2'd0, 1'b1, 2'd3, 16'h0000, 1'b1, 21'h090F0},  // R5 fetch ignores
    '{2'd3, 1'b1, 2'd1, 16'h0001, 1'b1, 21'h20001}   // R5 sdst ignores
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_seg(input logic [1:0] s, input logic [15:0] v);
    seg_we = 1; seg_wsel = s; seg_wdata = v;
    @(negedge clk);
    seg_we = 0;
  endtask

  task automatic do_req(input logic [1:0] a, input logic e, input logic [1:0] o,
                        input logic [15:0] f, input logic g20);
    acc = a; oen = e; osel = o; ofs = f; a20 = g20; req = 1;
    @(negedge clk);
    req = 0;
  endtask

  initial begin
    #(20ns * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R8 reset state
    chk("R8 pa after reset", 32'(pa), 32'h0);
    chk("R8 vld after reset", 32'(vld), 32'h0);
    rst_n = 1;
    @(negedge clk);
    do_req(2'd2, 0, 0, 16'h0025, 1);
    chk("R8 data seg zero", 32'(pa), 32'h00025);
    chk("R6 vld one cycle later", 32'(vld), 32'h1);
    @(negedge clk);
    chk("R6 vld drops", 32'(vld), 32'h0);
    chk("R6 pa holds", 32'(pa), 32'h00025);

    wr_seg(2'd0, 16'h090F);
    wr_seg(2'd1, 16'h0A0F);
    wr_seg(2'd2, 16'h2000);
    wr_seg(2'd3, 16'h0A28);

    foreach (VECS[i]) begin
      do_req(VECS[i].acc, VECS[i].oen, VECS[i].osel, VECS[i].ofs, VECS[i].a20);
      chk($sformatf("R3/R4/R5 vec %0d", i), 32'(pa), 32'(VECS[i].pa));
    end

    // R7 write without enable is ignored
    seg_wsel = 2'd1; seg_wdata = 16'h5555; seg_we = 0;
    @(negedge clk);
    do_req(2'd2, 0, 0, 16'h0000, 1);
    chk("R7 no write without enable", 32'(pa), 32'h0A0F0);

    // R1 / R2 high memory and wrap
    wr_seg(2'd1, 16'hFFFF);
    do_req(2'd2, 0, 0, 16'hFFFF, 1);
    chk("R1 top of high memory", 32'(pa), 32'h10FFEF);
    do_req(2'd2, 0, 0, 16'hFFFF, 0);
    chk("R2 wrap top", 32'(pa), 32'h0FFEF);
    do_req(2'd2, 0, 0, 16'h0010, 1);
    chk("R1 first byte above 1MB", 32'(pa), 32'h100000);
    do_req(2'd2, 0, 0, 16'h0010, 0);
    chk("R2 wrap to zero", 32'(pa), 32'h000000);
    do_req(2'd2, 0, 0, 16'h000F, 0);
    chk("R2 below 1MB unaffected", 32'(pa), 32'h0FFFFF);

    // R7 same-cycle write and request
    seg_we = 1; seg_wsel = 2'd1; seg_wdata = 16'h1234;
    do_req(2'd2, 0, 0, 16'h0000, 1);
    seg_we = 0;
    chk("R7 same cycle uses old", 32'(pa), 32'h0FFFF0);
    do_req(2'd2, 0, 0, 16'h0000, 1);
    chk("R7 next uses new", 32'(pa), 32'h12340);

    // R9 index stepping
    sidx = 16'h0010; sdir = 0; sword = 0; #1ns;
    chk("R9 byte up", 32'(sidx_o), 32'h0011);
    sdir = 1; sword = 1; #1ns;
    chk("R9 word down", 32'(sidx_o), 32'h000E);
    sidx = 16'h0000; sword = 0; #1ns;
    chk("R9 byte down wrap", 32'(sidx_o), 32'hFFFF);
    sidx = 16'hFFFF; sdir = 0; sword = 1; #1ns;
    chk("R9 word up wrap", 32'(sidx_o), 32'h0001);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule